// File: doc/BRIEF.md
# Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a processor. A rising edge on a request line sets a bit in the pending register. A mask register removes lines from consideration. The controller asserts its interrupt output when an unmasked pending request outranks every request already in service. When the processor pulses the acknowledge input, the controller does three things: it presents an 8-bit vector equal to a programmed base with the winning line number in its low three bits, it moves that request from pending to in-service, and it holds that priority level busy until an end-of-interrupt command releases it.

Priority is fixed by default, with line 0 highest and line 7 lowest. An optional rotating mode instead makes each line the lowest priority right after its non-specific end-of-interrupt. A small write port programs the vector base, the mask and the commands.

Sequencing uses three states:
- `ST_IDLE`: nothing to signal.
- `ST_REQ`: interrupt output driven.
- `ST_VEC`: vector presented for one cycle.

Transitions:
- IDLE to REQ: a request outranks all in-service levels.
- REQ to VEC: acknowledge accepted.
- REQ to IDLE: the qualifying request disappeared, for example through masking or end-of-interrupt ordering.
- VEC to IDLE: always, after one cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `vec_out` are 0, nothing is pending or in service, the mask is 0 (all lines enabled), the base is 0 and rotation is off.
- R2: A 0-to-1 change on `irq_in[i]` marks line i pending. A level held high after its acknowledge does not request again.
- R3: Writing `wr_addr`=1 loads the mask, where bit i=1 masks line i. A masked pending line never raises `int_out` and is never acknowledged. Clearing its mask bit later lets it raise `int_out`.
- R4: In fixed mode, when several lines are pending, the lowest-numbered unmasked line wins.
- R5: `int_out` is high exactly while the state is `ST_REQ` and some unmasked pending line outranks every in-service line. The state enters `ST_REQ` one clock after that condition first holds.
- R6: An `inta` pulse while `int_out` is high gives, in the next cycle only, `vec_valid`=1 and `vec_out` = {base[7:3], winning line}. It also sets that line's in-service bit and clears its pending bit. Writing `wr_addr`=0 loads the base, and its low three bits are ignored.
- R7: An `inta` pulse while `int_out` is low has no effect: `vec_valid` stays 0.
- R8: While line k is in service, pending lines of equal or lower priority do not raise `int_out`, but a higher-priority line does.
- R9: Writing `wr_addr`=2 with data[7:6]=01 is a non-specific end-of-interrupt: it clears the highest-priority in-service bit.
- R10: Writing `wr_addr`=2 with data[7:6]=10 is a specific end-of-interrupt: it clears the in-service bit numbered by data[2:0].
- R11: Writing `wr_addr`=2 with data[7:6]=11 sets rotation on when data[0]=1 and off when data[0]=0. With rotation on, a non-specific end-of-interrupt makes the line it cleared the lowest priority. Turning rotation off restores line 0 as highest.
- R12: Writes to `wr_addr`=3 change neither the base nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, rising edge sensitive |
| inta | input | 1 | Acknowledge pulse from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 base, 1 mask, 2 command, 3 unused |
| wr_data | input | 8 | Write data |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_out | output | 8 | Vector type number |

## Verification
The hardest condition to reach is two nested levels in service while lower and equal priority requests wait behind them. Reaching it shows that a non-specific end-of-interrupt releases only the inner level and keeps the waiting requests blocked. The stimulus builds this state step by step. It acknowledges line 3, re-raises lines 3 and 5, raises line 1 and acknowledges it, and then issues the two kinds of end-of-interrupt one at a time. A second sequence does the same with rotation on, so that the winning line after each end-of-interrupt differs from the fixed order.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_VEC  = 2'd2
    } pic_state_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_EOI_NS = 2'b01,
        OP_EOI_SP = 2'b10,
        OP_MODE   = 2'b11
    } pic_op_t;

    localparam logic [1:0] A_BASE = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_CMD  = 2'd2;

endpackage

// File: rtl/pic_prio_find.sv
// Finds the highest-priority set bit of vec, where priority runs upward
// from the position just above 'lowest', wrapping around.
module pic_prio_find #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic [N_IRQ-1:0]  vec,
    input  logic [IDX_W-1:0]  lowest,
    output logic              found,
    output logic [IDX_W-1:0]  idx,
    output logic [RANK_W-1:0] rank
);

    logic [IDX_W-1:0] pos;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = RANK_W'(N_IRQ);
        pos   = '0;
        for (int r = N_IRQ - 1; r >= 0; r--) begin
            pos = lowest + IDX_W'(1) + IDX_W'(r);
            if (vec[pos]) begin
                found = 1'b1;
                idx   = pos;
                rank  = RANK_W'(r);
            end
        end
    end

endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int HI_W = VEC_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    output logic [HI_W-1:0]  base_hi,
    output logic [N_IRQ-1:0] mask,
    output logic             rot_en,
    output logic             eoi_ns,
    output logic             eoi_sp,
    output logic [IDX_W-1:0] eoi_lvl
);

    pic_op_t op;
    logic    cmd_wr;

    assign op      = pic_op_t'(wr_data[VEC_W-1 -: 2]);
    assign cmd_wr  = wr_en && (wr_addr == A_CMD);
    assign eoi_ns  = cmd_wr && (op == OP_EOI_NS);
    assign eoi_sp  = cmd_wr && (op == OP_EOI_SP);
    assign eoi_lvl = wr_data[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi <= '0;
            mask    <= '0;
            rot_en  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_BASE) base_hi <= wr_data[VEC_W-1:IDX_W];
            if (wr_addr == A_MASK) mask    <= wr_data[N_IRQ-1:0];
            if (cmd_wr && op == OP_MODE) rot_en <= wr_data[0];
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_IRQ),
    localparam int RANK_W = IDX_W + 1,
    localparam int HI_W = VEC_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             inta,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    output logic             int_out,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    pic_state_t       state, state_nx;
    logic [N_IRQ-1:0] irq_q, irr, isr, irr_nx, isr_nx;
    logic [IDX_W-1:0] lowest, lowest_nx;
    logic [HI_W-1:0]  base_hi;
    logic [N_IRQ-1:0] mask;
    logic             rot_en, eoi_ns, eoi_sp;
    logic [IDX_W-1:0] eoi_lvl;
    logic             req_found, isr_found, cand_ok, ack_take;
    logic [IDX_W-1:0] req_idx, isr_idx;
    logic [RANK_W-1:0] req_rank, isr_rank;

    pic_cfg_regs #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .base_hi(base_hi), .mask(mask), .rot_en(rot_en),
        .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl)
    );

    pic_prio_find #(.N_IRQ(N_IRQ)) u_req_find (
        .vec(irr & ~mask), .lowest(lowest),
        .found(req_found), .idx(req_idx), .rank(req_rank)
    );

    pic_prio_find #(.N_IRQ(N_IRQ)) u_isr_find (
        .vec(isr), .lowest(lowest),
        .found(isr_found), .idx(isr_idx), .rank(isr_rank)
    );

    assign cand_ok  = req_found && (req_rank < isr_rank);
    assign ack_take = (state == ST_REQ) && inta && cand_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cand_ok)  state_nx = ST_REQ;
            ST_REQ:  if (ack_take) state_nx = ST_VEC;
                     else if (!cand_ok) state_nx = ST_IDLE;
            ST_VEC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // pending, in-service and rotation pointer updates
    always_comb begin
        irr_nx    = irr | (irq_in & ~irq_q);
        isr_nx    = isr;
        lowest_nx = rot_en ? lowest : IDX_W'(N_IRQ - 1);
        if (ack_take) begin
            irr_nx[req_idx] = 1'b0;
            isr_nx[req_idx] = 1'b1;
        end
        if (eoi_ns && isr_found) begin
            isr_nx[isr_idx] = 1'b0;
            if (rot_en) lowest_nx = isr_idx;
        end
        if (eoi_sp) isr_nx[eoi_lvl] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            irr    <= '0;
            isr    <= '0;
            lowest <= IDX_W'(N_IRQ - 1);
        end else begin
            irq_q  <= irq_in;
            irr    <= irr_nx;
            isr    <= isr_nx;
            lowest <= lowest_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vec_out <= '0;
        else if (ack_take) vec_out <= {base_hi, req_idx};
    end

    assign int_out   = (state == ST_REQ) && cand_ok;
    assign vec_valid = (state == ST_VEC);

    p_int_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr & ~mask)));

    p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> isr[$past(req_idx)]);

    p_masked_not_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & ~$past(isr)) & $past(mask)) == '0);

    p_ignore_inta_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out) |=> !vec_valid);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       inta = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // base, lines raised together, expected vector
    localparam logic [23:0] TBL [5] = '{
        {8'h08, 8'h01, 8'h08},
        {8'h08, 8'hA0, 8'h0D},
        {8'h20, 8'h06, 8'h21},
        {8'hF8, 8'h80, 8'hFF},
        {8'h4D, 8'h18, 8'h4B}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pulse acknowledge; returns with vector outputs sampled
    task automatic ack(output logic v, output logic [7:0] vo);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec_valid; vo = vec_out;
    endtask

    task automatic drive(input logic [7:0] lines);
        @(negedge clk);
        irq_in = lines;
        settle(3);
    endtask

    logic       v;
    logic [7:0] vo;

    initial begin
        settle(2);
        // R1 reset state
        chk("R1 int_out", int_out, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec_out", vec_out, 0);
        rst_n = 1'b1;
        settle(2);
        chk("R1 int after reset", int_out, 0);

        // R7 acknowledge with nothing pending
        ack(v, vo);
        chk("R7 vec_valid idle", v, 0);

        // table of priority and vector cases (R4, R6)
        for (int k = 0; k < 5; k++) begin
            wr(2'd0, TBL[k][23:16]);
            drive(TBL[k][15:8]);
            chk("R5 int raised", int_out, 1);
            ack(v, vo);
            chk("R6 vec_valid", v, 1);
            chk("R4/R6 vector", vo, TBL[k][7:0]);
            @(negedge clk);
            chk("R6 vec_valid one cycle", vec_valid, 0);
            irq_in = '0;
            for (int j = 0; j < 8; j++) begin
                wr(2'd2, 8'h40);
                settle(3);
                if (int_out) ack(v, vo);
            end
            chk("R9 drained", int_out, 0);
        end

        wr(2'd0, 8'h08);

        // R3 masking
        wr(2'd1, 8'h04);
        drive(8'h04);
        chk("R3 masked no int", int_out, 0);
        ack(v, vo);
        chk("R3 masked not acked", v, 0);
        wr(2'd1, 8'h00);
        settle(3);
        chk("R3 unmasked int", int_out, 1);
        ack(v, vo);
        chk("R3 unmasked vector", vo, 8'h0A);
        wr(2'd2, 8'h40);
        drive(8'h00);

        // R2 held level does not re-request
        drive(8'h20);
        ack(v, vo);
        chk("R2 vector", vo, 8'h0D);
        wr(2'd2, 8'h40);
        settle(3);
        chk("R2 no re-request", int_out, 0);
        drive(8'h00);

        // R8 nesting, R9 and R10 end-of-interrupt
        drive(8'h08);
        ack(v, vo);
        chk("R8 first vector", vo, 8'h0B);
        drive(8'h00);
        drive(8'h28);
        chk("R8 equal/lower blocked", int_out, 0);
        drive(8'h2A);
        chk("R8 higher passes", int_out, 1);
        ack(v, vo);
        chk("R8 nested vector", vo, 8'h09);
        irq_in = '0;
        wr(2'd2, 8'h40);
        settle(3);
        chk("R9 inner cleared, outer blocks", int_out, 0);
        wr(2'd2, 8'h83);
        settle(3);
        chk("R10 specific eoi releases", int_out, 1);
        ack(v, vo);
        chk("R4 line 3 before 5", vo, 8'h0B);
        wr(2'd2, 8'h40);
        settle(3);
        ack(v, vo);
        chk("R4 then line 5", vo, 8'h0D);
        wr(2'd2, 8'h40);
        settle(3);
        chk("R9 all clear", int_out, 0);

        // R11 rotation
        wr(2'd2, 8'hC1);
        drive(8'h44);
        ack(v, vo);
        chk("R11 first line 2", vo, 8'h0A);
        wr(2'd2, 8'h40);
        settle(3);
        ack(v, vo);
        chk("R11 then line 6", vo, 8'h0E);
        wr(2'd2, 8'h40);
        drive(8'h00);
        drive(8'h81);
        ack(v, vo);
        chk("R11 rotated line 7 first", vo, 8'h0F);
        wr(2'd2, 8'h40);
        settle(3);
        ack(v, vo);
        chk("R11 then line 0", vo, 8'h08);
        wr(2'd2, 8'h40);
        drive(8'h00);
        wr(2'd2, 8'hC0);
        drive(8'h81);
        ack(v, vo);
        chk("R11 fixed restored", vo, 8'h08);
        wr(2'd2, 8'h40);
        settle(3);
        ack(v, vo);
        wr(2'd2, 8'h40);
        drive(8'h00);

        // R12 unused address
        wr(2'd3, 8'hFF);
        drive(8'h10);
        chk("R12 mask untouched", int_out, 1);
        ack(v, vo);
        chk("R12 base untouched", vo, 8'h0C);
        wr(2'd2, 8'h40);

        settle(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule